// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the memory-mapped register file of a simple LCD controller, together with the logic that drives its single level interrupt. A plain register port gives access to six words. They hold the control fields (run enable, monochrome, TFT panel type, palette-loading mode and a two-bit interrupt mask), two dimension words that each carry a 10-bit size plus upper timing bits, a third timing word, a read-only status word and a subpanel word. Some fields are stored under a write mask. Some words read back with fixed bits forced to one.

A frame sequencer outside the block reports three events through set inputs: frame done, palette done and sync error. Each event sets a sticky flag. The interrupt merges the flags with the mask. The run enable is tracked by a two-state machine with states ST_OFF and ST_ON. The transition T_START (a control write with bit 0 set while in ST_OFF) clears the frame-done and palette-done flags. The transition T_STOP (a control write with bit 0 clear while in ST_ON) clears sync error and sets frame done, except when the palette mode being written is 1. Any other control write keeps the state. Each transition emits a one-cycle strobe that tells the sequencer to restart or halt.

Top module: `lcd_regif`

## Requirements
- R1: After reset, all fields, flags, dimensions and the subpanel are zero. Reads then return 0xFE000C34 (control at 0x00), 0xFFFFFFFF (0x04 and 0x08, because the size reads back as size minus one), 0xFC000000 (0x0C), 0 (status at 0x10) and 0 (subpanel at 0x14). irq, bad_addr and en_changed are low.
- R2: Control write at offset 0x00 uses these bits: bit 0 enable, bit 1 mono, bits 4:3 interrupt mask, bit 7 TFT, bits 21:20 palette mode, plus the bits under mask 0x01CFF300. A read returns those fields with TFT also copied to bit 23, ORed with 0xFE000C34.
- R3: A write to 0x04 stores size = bits 9:0 plus one as the width, and bits 31:10 as timing. A read returns timing<<10 | (width-1) | 0xF.
- R4: A write to 0x08 stores the height the same way. A read returns timing<<10 | (height-1).
- R5: A write to 0x0C stores the whole word. A read returns it ORed with 0xFC000000.
- R6: A write to 0x14 stores the value ANDed with 0xA1FFFFFF, and a read returns it.
- R7: Status at 0x10 has frame done at bit 0, sync error at bit 2 and palette done at bit 6. A write to 0x10 changes no flag.
- R8: irq is high when frame done and mask bit 0 are both set, or palette done and mask bit 1 are both set, or sync error is set (whatever the mask). Otherwise irq is low. A flag set by a sequencer input appears one cycle after the input.
- R9: T_STOP clears sync error. It sets frame done unless the palette mode in the same write is 1, in which case frame done keeps its value.
- R10: T_START clears frame done and palette done.
- R11: An access to any offset other than the six mapped ones reads zero and pulses bad_addr for exactly one cycle, in the cycle after the access.
- R12: Each T_START or T_STOP pulses en_changed for one cycle, in the cycle after the write. A control write that leaves enable unchanged does not pulse it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr (combinational) |
| seq_set_frame | input | 1 | Sequencer: frame finished |
| seq_set_palette | input | 1 | Sequencer: palette loaded |
| seq_set_sync | input | 1 | Sequencer: sync error |
| irq | output | 1 | Level interrupt |
| bad_addr | output | 1 | Unmapped-access pulse |
| en_changed | output | 1 | Enable-transition strobe |
| cfg_enable | output | 1 | Run enable (state ST_ON) |
| cfg_mono | output | 1 | Monochrome field |
| cfg_tft | output | 1 | TFT panel field |
| cfg_plm | output | 2 | Palette-loading mode |
| cfg_width | output | DIM_W+1 | Width in pixels |
| cfg_height | output | DIM_W+1 | Height in lines |

## Verification
The assertions assume that the sequencer set inputs and the access signals are clean, synchronous levels, each held for whole cycles. They assume a write counts only when acc_valid is high. The status-write property holds only in cycles where no set input is active. The bench therefore drives every input on the falling edge, issues at most one access per cycle, and keeps the set inputs low during any write it uses to show that a status write is ignored.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;
    localparam int DATA_W = 32;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } lcd_run_e;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_DIM_X  = 8'h04;
    localparam logic [7:0] OFS_DIM_Y  = 8'h08;
    localparam logic [7:0] OFS_TIM_Z  = 8'h0C;
    localparam logic [7:0] OFS_STAT   = 8'h10;
    localparam logic [7:0] OFS_SUBP   = 8'h14;

    localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [DATA_W-1:0] CTRL_RD_ONES   = 32'hFE00_0C34;
    localparam logic [DATA_W-1:0] DIMX_RD_ONES   = 32'h0000_000F;
    localparam logic [DATA_W-1:0] TIMZ_RD_ONES   = 32'hFC00_0000;
    localparam logic [DATA_W-1:0] SUBP_KEEP_MASK = 32'hA1FF_FFFF;
endpackage

// File: rtl/lcd_regbank.sv
module lcd_regbank
    import lcd_regif_pkg::*;
#(
    parameter int DIM_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_ctrl,
    input  logic [1:0]                   wr_dim,
    input  logic                         wr_timz,
    input  logic                         wr_subp,
    input  logic [DATA_W-1:0]            wdata,
    output logic                         mono,
    output logic                         tft,
    output logic [1:0]                   imask,
    output logic [1:0]                   plm,
    output logic [DATA_W-1:0]            ctrl_keep,
    output logic [1:0][DATA_W-DIM_W-1:0] tim_hi,
    output logic [1:0][DIM_W:0]          dim,
    output logic [DATA_W-1:0]            timz,
    output logic [DATA_W-1:0]            subp
);
    localparam int TIM_W = DATA_W - DIM_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mono      <= 1'b0;
            tft       <= 1'b0;
            imask     <= 2'b00;
            plm       <= 2'b00;
            ctrl_keep <= '0;
        end else if (wr_ctrl) begin
            mono      <= wdata[1];
            tft       <= wdata[7];
            imask     <= wdata[4:3];
            plm       <= wdata[21:20];
            ctrl_keep <= wdata & CTRL_KEEP_MASK;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_dim
        logic [TIM_W-1:0] hi_q;
        logic [DIM_W:0]   size_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q   <= '0;
                size_q <= '0;
            end else if (wr_dim[g]) begin
                hi_q   <= wdata[DATA_W-1:DIM_W];
                size_q <= {1'b0, wdata[DIM_W-1:0]} + (DIM_W+1)'(1);
            end
        end
        assign tim_hi[g] = hi_q;
        assign dim[g]    = size_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timz <= '0;
            subp <= '0;
        end else begin
            if (wr_timz) timz <= wdata;
            if (wr_subp) subp <= wdata & SUBP_KEEP_MASK;
        end
    end
endmodule

// File: rtl/lcd_run_fsm.sv
module lcd_run_fsm
    import lcd_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       wr_en_bit,
    input  logic [1:0] wr_plm,
    input  logic       set_frame,
    input  logic       set_pal,
    input  logic       set_sync,
    output logic       run_en,
    output logic       frame_done,
    output logic       pal_done,
    output logic       sync_err,
    output logic       en_changed
);
    lcd_run_e state_q, state_d;
    logic     t_start, t_stop;

    always_comb begin
        state_d = state_q;
        t_start = 1'b0;
        t_stop  = 1'b0;
        unique case (state_q)
            ST_OFF: if (ctrl_wr && wr_en_bit) begin
                state_d = ST_ON;
                t_start = 1'b1;
            end
            ST_ON: if (ctrl_wr && !wr_en_bit) begin
                state_d = ST_OFF;
                t_stop  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            pal_done   <= 1'b0;
            sync_err   <= 1'b0;
            en_changed <= 1'b0;
        end else begin
            en_changed <= t_start || t_stop;
            if (t_start) begin
                frame_done <= 1'b0;
                pal_done   <= 1'b0;
                sync_err   <= sync_err || set_sync;
            end else if (t_stop) begin
                frame_done <= (wr_plm != 2'd1) ? 1'b1 : (frame_done || set_frame);
                pal_done   <= pal_done || set_pal;
                sync_err   <= 1'b0;
            end else begin
                frame_done <= frame_done || set_frame;
                pal_done   <= pal_done || set_pal;
                sync_err   <= sync_err || set_sync;
            end
        end
    end

    assign run_en = (state_q == ST_ON);
endmodule

// File: rtl/lcd_irq_merge.sv
module lcd_irq_merge (
    input  logic       frame_done,
    input  logic       pal_done,
    input  logic       sync_err,
    input  logic [1:0] imask,
    output logic       irq
);
    logic frame_hit, pal_hit;

    assign frame_hit = frame_done && imask[0];
    assign pal_hit   = pal_done && imask[1];
    assign irq       = frame_hit || pal_hit || sync_err;
endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
    import lcd_regif_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIM_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic              seq_set_frame,
    input  logic              seq_set_palette,
    input  logic              seq_set_sync,
    output logic              irq,
    output logic              bad_addr,
    output logic              en_changed,
    output logic              cfg_enable,
    output logic              cfg_mono,
    output logic              cfg_tft,
    output logic [1:0]        cfg_plm,
    output logic [DIM_W:0]    cfg_width,
    output logic [DIM_W:0]    cfg_height
);
    localparam int TIM_W = DATA_W - DIM_W;

    logic hit_ctrl, hit_dimx, hit_dimy, hit_timz, hit_stat, hit_subp, hit_any;
    logic do_wr;
    logic [1:0]                imask;
    logic [DATA_W-1:0]         ctrl_keep, timz, subp;
    logic [1:0][TIM_W-1:0]     tim_hi;
    logic [1:0][DIM_W:0]       dim;
    logic                      frame_done, pal_done, sync_err;

    assign hit_ctrl = (acc_addr == ADDR_W'(OFS_CTRL));
    assign hit_dimx = (acc_addr == ADDR_W'(OFS_DIM_X));
    assign hit_dimy = (acc_addr == ADDR_W'(OFS_DIM_Y));
    assign hit_timz = (acc_addr == ADDR_W'(OFS_TIM_Z));
    assign hit_stat = (acc_addr == ADDR_W'(OFS_STAT));
    assign hit_subp = (acc_addr == ADDR_W'(OFS_SUBP));
    assign hit_any  = hit_ctrl | hit_dimx | hit_dimy | hit_timz | hit_stat | hit_subp;
    assign do_wr    = acc_valid && acc_write;

    lcd_regbank #(.DIM_W(DIM_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (do_wr && hit_ctrl),
        .wr_dim    ({do_wr && hit_dimy, do_wr && hit_dimx}),
        .wr_timz   (do_wr && hit_timz),
        .wr_subp   (do_wr && hit_subp),
        .wdata     (acc_wdata),
        .mono      (cfg_mono),
        .tft       (cfg_tft),
        .imask     (imask),
        .plm       (cfg_plm),
        .ctrl_keep (ctrl_keep),
        .tim_hi    (tim_hi),
        .dim       (dim),
        .timz      (timz),
        .subp      (subp)
    );

    lcd_run_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (do_wr && hit_ctrl),
        .wr_en_bit  (acc_wdata[0]),
        .wr_plm     (acc_wdata[21:20]),
        .set_frame  (seq_set_frame),
        .set_pal    (seq_set_palette),
        .set_sync   (seq_set_sync),
        .run_en     (cfg_enable),
        .frame_done (frame_done),
        .pal_done   (pal_done),
        .sync_err   (sync_err),
        .en_changed (en_changed)
    );

    lcd_irq_merge u_irq (
        .frame_done (frame_done),
        .pal_done   (pal_done),
        .sync_err   (sync_err),
        .imask      (imask),
        .irq        (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) bad_addr <= 1'b0;
        else        bad_addr <= acc_valid && !hit_any;
    end

    assign cfg_width  = dim[0];
    assign cfg_height = dim[1];

    always_comb begin
        acc_rdata = '0;
        if (hit_ctrl)
            acc_rdata = CTRL_RD_ONES | ctrl_keep | (32'(cfg_tft) << 23) |
                        (32'(cfg_plm) << 20) | (32'(cfg_tft) << 7) |
                        (32'(imask) << 3) | (32'(cfg_mono) << 1) | 32'(cfg_enable);
        else if (hit_dimx)
            acc_rdata = {tim_hi[0], DIM_W'(0)} | (32'(dim[0]) - 32'd1) | DIMX_RD_ONES;
        else if (hit_dimy)
            acc_rdata = {tim_hi[1], DIM_W'(0)} | (32'(dim[1]) - 32'd1);
        else if (hit_timz)
            acc_rdata = timz | TIMZ_RD_ONES;
        else if (hit_stat)
            acc_rdata = 32'({pal_done, 3'b000, sync_err, 1'b0, frame_done});
        else if (hit_subp)
            acc_rdata = subp;
    end
endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [31:0]       acc_wdata,
    input logic              seq_set_frame,
    input logic              seq_set_palette,
    input logic              seq_set_sync,
    input logic              irq,
    input logic              bad_addr,
    input logic              en_changed,
    input logic              cfg_enable,
    input logic              frame_done,
    input logic              pal_done,
    input logic              sync_err
);
    logic ctrl_wr, stat_wr, no_sets;
    assign ctrl_wr = acc_valid && acc_write && (acc_addr == ADDR_W'(8'h00));
    assign stat_wr = acc_valid && acc_write && (acc_addr == ADDR_W'(8'h10));
    assign no_sets = !seq_set_frame && !seq_set_palette && !seq_set_sync;

    AST_SYNC_FORCES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> irq); // R8
    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !pal_done && !sync_err) |-> !irq); // R8
    AST_STOP_CLEARS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !acc_wdata[0] && cfg_enable) |=> !sync_err); // R9
    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && acc_wdata[0] && !cfg_enable) |=> (!frame_done && !pal_done)); // R10
    AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en_changed |-> (cfg_enable != $past(cfg_enable))); // R12
    AST_BAD_ADDR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_addr |-> $past(acc_valid)); // R11
    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && no_sets) |=> $stable({frame_done, pal_done, sync_err})); // R7
endmodule

bind lcd_regif lcd_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_write       (acc_write),
    .acc_addr        (acc_addr),
    .acc_wdata       (acc_wdata),
    .seq_set_frame   (seq_set_frame),
    .seq_set_palette (seq_set_palette),
    .seq_set_sync    (seq_set_sync),
    .irq             (irq),
    .bad_addr        (bad_addr),
    .en_changed      (en_changed),
    .cfg_enable      (cfg_enable),
    .frame_done      (frame_done),
    .pal_done        (pal_done),
    .sync_err        (sync_err)
);

// File: tb/tb_lcd_regif.sv
module tb_lcd_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        seq_set_frame = 1'b0;
    logic        seq_set_palette = 1'b0;
    logic        seq_set_sync = 1'b0;
    logic        irq, bad_addr, en_changed, cfg_enable, cfg_mono, cfg_tft;
    logic [1:0]  cfg_plm;
    logic [10:0] cfg_width, cfg_height;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lcd_regif dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .seq_set_frame(seq_set_frame), .seq_set_palette(seq_set_palette),
        .seq_set_sync(seq_set_sync), .irq(irq), .bad_addr(bad_addr),
        .en_changed(en_changed), .cfg_enable(cfg_enable), .cfg_mono(cfg_mono),
        .cfg_tft(cfg_tft), .cfg_plm(cfg_plm), .cfg_width(cfg_width),
        .cfg_height(cfg_height)
    );

    // {offset, write data, expected read-back}
    localparam int NV = 14;
    localparam logic [71:0] VEC [NV] = '{
        {8'h00, 32'hFFFF_FFFE, 32'hFFFF_FFBE},  // R2 all fields
        {8'h00, 32'h0000_0000, 32'hFE00_0C34},  // R2 none
        {8'h00, 32'h0000_0080, 32'hFE80_0CB4},  // R2 tft mirror
        {8'h04, 32'h0000_0000, 32'h0000_000F},  // R3 width 1
        {8'h04, 32'h1234_5678, 32'h1234_567F},  // R3
        {8'h04, 32'h0000_03FF, 32'h0000_03FF},  // R3 max width
        {8'h08, 32'hABCD_E3FF, 32'hABCD_E3FF},  // R4
        {8'h08, 32'h0000_0000, 32'h0000_0000},  // R4
        {8'h0C, 32'h0123_ABCD, 32'hFD23_ABCD},  // R5
        {8'h14, 32'hFFFF_FFFF, 32'hA1FF_FFFF},  // R6
        {8'h14, 32'h5E00_0001, 32'h0000_0001},  // R6
        {8'h10, 32'hFFFF_FFFF, 32'h0000_0000},  // R7 ignored
        {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
        {8'h0C, 32'hFFFF_FFFF, 32'hFFFF_FFFF}   // R5
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        seq_set_frame   = (which == 0);
        seq_set_palette = (which == 1);
        seq_set_sync    = (which == 2);
        @(negedge clk);
        seq_set_frame = 1'b0; seq_set_palette = 1'b0; seq_set_sync = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 bad_addr", 32'(bad_addr), 32'd0);
        check("R1 en_changed", 32'(en_changed), 32'd0);
        rd(8'h00, r); check("R1 ctrl", r, 32'hFE00_0C34);
        rd(8'h04, r); check("R1 dimx", r, 32'hFFFF_FFFF);
        rd(8'h08, r); check("R1 dimy", r, 32'hFFFF_FFFF);
        rd(8'h0C, r); check("R1 timz", r, 32'hFC00_0000);
        rd(8'h10, r); check("R1 status", r, 32'h0);
        rd(8'h14, r); check("R1 subpanel", r, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:64], VEC[i][63:32]);
            rd(VEC[i][71:64], r);
            check($sformatf("vector %0d (R2..R7,R11)", i), r, VEC[i][31:0]);
        end
        wr(8'h04, 32'h0000_0013);
        check("R3 width port", 32'(cfg_width), 32'd20);

        // R8 interrupt merging (control now: tft only, mask 0)
        pulse(0);
        rd(8'h10, r); check("R7 frame bit0", r, 32'h01);
        check("R8 masked frame", 32'(irq), 32'd0);
        wr(8'h00, 32'h0000_0008);
        check("R8 frame mask0", 32'(irq), 32'd1);
        pulse(1);
        rd(8'h10, r); check("R7 palette bit6", r, 32'h41);
        wr(8'h10, 32'h0000_0000);
        rd(8'h10, r); check("R7 status write ignored", r, 32'h41);
        wr(8'h00, 32'h0000_0010);
        check("R8 palette mask1", 32'(irq), 32'd1);
        wr(8'h00, 32'h0000_0000);
        check("R8 both masked", 32'(irq), 32'd0);
        pulse(2);
        rd(8'h10, r); check("R7 sync bit2", r, 32'h45);
        check("R8 sync unmasked", 32'(irq), 32'd1);

        // R10 / R12 start
        wr(8'h00, 32'h0000_0001);
        check("R12 strobe on start", 32'(en_changed), 32'd1);
        @(negedge clk);
        check("R12 strobe one cycle", 32'(en_changed), 32'd0);
        rd(8'h10, r); check("R10 start clears done", r, 32'h04);
        rd(8'h00, r); check("R2 enable readback", r, 32'hFE00_0C35);
        wr(8'h00, 32'h0010_0001);
        check("R12 no strobe same enable", 32'(en_changed), 32'd0);

        // R9 stop with palette mode 1
        wr(8'h00, 32'h0010_0000);
        check("R12 strobe on stop", 32'(en_changed), 32'd1);
        rd(8'h10, r); check("R9 stop plm1", r, 32'h00);
        check("R8 irq low after stop", 32'(irq), 32'd0);

        // R9 stop with palette mode 0
        wr(8'h00, 32'h0000_0001);
        pulse(2);
        wr(8'h00, 32'h0000_0000);
        rd(8'h10, r); check("R9 stop plm0", r, 32'h01);

        // R11 unmapped access
        rd(8'h1C, r);
        check("R11 unmapped reads zero", r, 32'h0);
        check("R11 bad_addr pulse", 32'(bad_addr), 32'd1);
        @(negedge clk);
        check("R11 bad_addr one cycle", 32'(bad_addr), 32'd0);
        rd(8'h14, r);
        check("R11 mapped no pulse", 32'(bad_addr), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule